// File: doc/BRIEF.md
# DSCP to TID classification table

This block converts the 6-bit differentiated-services code point of a packet into a 3-bit traffic identifier. It keeps two independent tables of 64 entries each. Every entry is 3 bits wide, and the entries sit back to back in 32-bit words, so a few of them cross a word boundary. Software loads the tables through a simple word-wide register bus. The transmit path queries a table through a lookup port and gets its answer one cycle later.

Map words can be changed only while a program-enable bit is set in a separate control register. Software sets the bit, updates the words and then clears the bit again. To change a single entry, software reads the one or two words that hold it, replaces only those 3 bits and writes the words back.

Top module: `dscp_tid_classifier`

## Requirements
- R1: After reset, every entry of both tables reads as TID 0, the program-enable bit is 0, and tid_valid is 0.
- R2: Map words sit at bus word addresses 0 to 11. Table n occupies addresses 6n to 6n+5. Word k of a table holds bits 32k to 32k+31 of the table's 192-bit string, least significant bit first. The TID for DSCP d is the 3 bits starting at bit 3d of that string.
- R3: An entry that crosses a word boundary (DSCP 10, 21, 42 and 53) takes its low bits from the top of word k and its high bits from the bottom of word k+1, and a lookup returns the assembled value.
- R4: A lookup request sets tid_valid exactly one cycle later, with tid and tid_err valid in that same cycle. If there is no request, tid_valid is 0 in the following cycle.
- R5: A lookup with a table selector of 2 or more returns tid 0 with tid_err 1. A valid selector (0 or 1) returns tid_err 0.
- R6: While program-enable is 0, writes to map words are dropped. Map words can be read at any time, whatever the state of program-enable.
- R7: The control register is at word address 16. Bit 0 is program-enable. The other bits always read as 0.
- R8: Writes to addresses 12 to 15 and 17 to 31 change nothing. Reads of those addresses return 0.
- R9: If a map-word write and a lookup happen in the same cycle, the lookup returns the value from before the write. A lookup in the next cycle sees the new value.
- R10: A bus read request puts the addressed word on bus_rdata one cycle later. A map word reads back exactly the 32 bits last written to it while program-enable was set.
- R11: A read-modify-write of one entry changes only that entry's lookup result. All other entries of both tables keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Word write strobe |
| bus_rd | input | 1 | Word read strobe |
| bus_addr | input | 5 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| lk_req | input | 1 | Lookup request |
| lk_dscp | input | 6 | Code point to classify |
| lk_sel | input | 2 | Table selector |
| tid_valid | output | 1 | Lookup result valid |
| tid | output | 3 | Traffic identifier |
| tid_err | output | 1 | Selector out of range |

## Verification
Both bus read data and lookup results are registered once, so each is due at the first rising edge after its request. The bench drives every request on a falling edge and samples the result on the next falling edge, exactly one register stage later. A write takes effect at the edge that accepts it. The bench therefore checks same-cycle write and lookup collisions in that same sampling slot, and checks the new value with a lookup issued one cycle after the write. The tid_valid drop is checked one further falling edge on, after the request has been removed.

// File: rtl/dtc_pkg.sv
// Shared constants and types for the DSCP to TID classifier.
// Assumes a word-addressed register bus with one control register.
package dtc_pkg;
    localparam int DEF_NUM_TABLES = 2;
    localparam int DEF_DSCP_W     = 6;
    localparam int DEF_TID_W      = 3;
    localparam int DEF_WORD_W     = 32;
    localparam int DEF_ADDR_W     = 5;
    localparam int DEF_SEL_W      = 2;
    localparam int DEF_CTRL_ADDR  = 16;

    // Bus address regions.
    typedef enum logic [1:0] {
        RGN_NONE = 2'd0,
        RGN_MAP  = 2'd1,
        RGN_CTRL = 2'd2
    } region_e;
endpackage

// File: rtl/dtc_decode.sv
// Address decoder: sorts a bus word address into map, control or unmapped.
// Assumes map words occupy the lowest addresses, starting at 0.
module dtc_decode
    import dtc_pkg::*;
#(
    parameter int ADDR_W    = DEF_ADDR_W,
    parameter int MAP_WORDS = 12,
    parameter int CTRL_ADDR = DEF_CTRL_ADDR,
    parameter int MAP_IDX_W = 4
) (
    input  logic [ADDR_W-1:0]    addr,
    output region_e              region,
    output logic [MAP_IDX_W-1:0] map_idx
);
    // Classify the address and extract the map word index.
    always_comb begin
        map_idx = MAP_IDX_W'(addr);
        if (int'(addr) < MAP_WORDS)
            region = RGN_MAP;
        else if (int'(addr) == CTRL_ADDR)
            region = RGN_CTRL;
        else
            region = RGN_NONE;
    end
endmodule

// File: rtl/dtc_store.sv
// Register store: the map words, the program-enable bit and the read port.
// Map writes are accepted only while program-enable is set. Reads are
// registered and return 0 for unmapped addresses.
module dtc_store
    import dtc_pkg::*;
#(
    parameter int WORD_W    = DEF_WORD_W,
    parameter int MAP_WORDS = 12,
    parameter int MAP_IDX_W = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          bus_wr,
    input  logic                          bus_rd,
    input  region_e                       region,
    input  logic [MAP_IDX_W-1:0]          map_idx,
    input  logic [WORD_W-1:0]             bus_wdata,
    output logic [WORD_W-1:0]             bus_rdata,
    output logic                          prog_en,
    output logic [MAP_WORDS*WORD_W-1:0]   map_flat
);
    logic [WORD_W-1:0] words [MAP_WORDS];
    logic              map_wr;

    assign map_wr = bus_wr && (region == RGN_MAP) && prog_en;

    // Program-enable bit of the control register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            prog_en <= 1'b0;
        else if (bus_wr && region == RGN_CTRL)
            prog_en <= bus_wdata[0];
    end

    // One register per map word, plus its slot in the flat view.
    for (genvar i = 0; i < MAP_WORDS; i++) begin : g_word
        always_ff @(posedge clk) begin
            if (!rst_n)
                words[i] <= '0;
            else if (map_wr && map_idx == MAP_IDX_W'(i))
                words[i] <= bus_wdata;
        end
        assign map_flat[i*WORD_W +: WORD_W] = words[i];
    end

    // Registered read mux over the address regions.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bus_rdata <= '0;
        else if (bus_rd) begin
            case (region)
                RGN_MAP:  bus_rdata <= words[map_idx];
                RGN_CTRL: bus_rdata <= {{(WORD_W-1){1'b0}}, prog_en};
                default:  bus_rdata <= '0;
            endcase
        end
    end
endmodule

// File: rtl/dtc_lookup.sv
// Lookup stage: picks the TID bits out of the flat table string and
// registers the result. Out-of-range selectors return 0 and flag an error.
// Assumes each table owns TABLE_BITS consecutive bits of the flat string.
module dtc_lookup #(
    parameter int NUM_TABLES = 2,
    parameter int DSCP_W     = 6,
    parameter int TID_W      = 3,
    parameter int SEL_W      = 2,
    parameter int TABLE_BITS = 192,
    parameter int FLAT_BITS  = 384,
    parameter int TBL_IDX_W  = 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [FLAT_BITS-1:0] map_flat,
    input  logic                 lk_req,
    input  logic [DSCP_W-1:0]    lk_dscp,
    input  logic [SEL_W-1:0]     lk_sel,
    output logic                 tid_valid,
    output logic [TID_W-1:0]     tid,
    output logic                 tid_err
);
    localparam int OFF_W = $clog2(FLAT_BITS);

    logic [OFF_W-1:0] bit_off;
    logic             sel_ok;

    // Bit offset of the entry: table base plus 3 bits per code point.
    always_comb begin
        sel_ok  = int'(lk_sel) < NUM_TABLES;
        bit_off = OFF_W'(lk_sel[TBL_IDX_W-1:0]) * OFF_W'(TABLE_BITS)
                + OFF_W'(lk_dscp) * OFF_W'(TID_W);
    end

    // Result register, loaded on each request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tid_valid <= 1'b0;
            tid       <= '0;
            tid_err   <= 1'b0;
        end else begin
            tid_valid <= lk_req;
            if (lk_req) begin
                tid     <= sel_ok ? map_flat[bit_off +: TID_W] : '0;
                tid_err <= !sel_ok;
            end
        end
    end
endmodule

// File: rtl/dscp_tid_classifier.sv
// DSCP to TID classifier top: a register bus for the map words and the
// control register, and a one-cycle registered lookup port.
// Assumes the tables are packed with no padding between them.
module dscp_tid_classifier
    import dtc_pkg::*;
#(
    parameter int NUM_TABLES = DEF_NUM_TABLES,
    parameter int DSCP_W     = DEF_DSCP_W,
    parameter int TID_W      = DEF_TID_W,
    parameter int WORD_W     = DEF_WORD_W,
    parameter int ADDR_W     = DEF_ADDR_W,
    parameter int SEL_W      = DEF_SEL_W,
    parameter int CTRL_ADDR  = DEF_CTRL_ADDR
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    input  logic              lk_req,
    input  logic [DSCP_W-1:0] lk_dscp,
    input  logic [SEL_W-1:0]  lk_sel,
    output logic              tid_valid,
    output logic [TID_W-1:0]  tid,
    output logic              tid_err
);
    localparam int ENTRIES    = 1 << DSCP_W;
    localparam int WPT        = (ENTRIES * TID_W + WORD_W - 1) / WORD_W;
    localparam int TABLE_BITS = WPT * WORD_W;
    localparam int MAP_WORDS  = NUM_TABLES * WPT;
    localparam int FLAT_BITS  = MAP_WORDS * WORD_W;
    localparam int MAP_IDX_W  = (MAP_WORDS > 1) ? $clog2(MAP_WORDS) : 1;
    localparam int TBL_IDX_W  = (NUM_TABLES > 1) ? $clog2(NUM_TABLES) : 1;

    region_e                region;
    logic [MAP_IDX_W-1:0]   map_idx;
    logic                   prog_en;
    logic [FLAT_BITS-1:0]   map_flat;

    dtc_decode #(
        .ADDR_W(ADDR_W), .MAP_WORDS(MAP_WORDS),
        .CTRL_ADDR(CTRL_ADDR), .MAP_IDX_W(MAP_IDX_W)
    ) u_dec (
        .addr(bus_addr), .region(region), .map_idx(map_idx)
    );

    dtc_store #(
        .WORD_W(WORD_W), .MAP_WORDS(MAP_WORDS), .MAP_IDX_W(MAP_IDX_W)
    ) u_store (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .region(region), .map_idx(map_idx), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .prog_en(prog_en), .map_flat(map_flat)
    );

    dtc_lookup #(
        .NUM_TABLES(NUM_TABLES), .DSCP_W(DSCP_W), .TID_W(TID_W),
        .SEL_W(SEL_W), .TABLE_BITS(TABLE_BITS), .FLAT_BITS(FLAT_BITS),
        .TBL_IDX_W(TBL_IDX_W)
    ) u_lk (
        .clk(clk), .rst_n(rst_n), .map_flat(map_flat), .lk_req(lk_req),
        .lk_dscp(lk_dscp), .lk_sel(lk_sel), .tid_valid(tid_valid),
        .tid(tid), .tid_err(tid_err)
    );
endmodule

// File: rtl/dtc_checker.sv
// Property checker for the classifier, bound to the top module.
module dtc_checker #(
    parameter int NUM_TABLES = 2,
    parameter int TID_W      = 3,
    parameter int WORD_W     = 32,
    parameter int ADDR_W     = 5,
    parameter int SEL_W      = 2,
    parameter int CTRL_ADDR  = 16,
    parameter int MAP_WORDS  = 12,
    parameter int FLAT_BITS  = 384
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 bus_rd,
    input logic [ADDR_W-1:0]    bus_addr,
    input logic [WORD_W-1:0]    bus_rdata,
    input logic                 lk_req,
    input logic [SEL_W-1:0]     lk_sel,
    input logic                 tid_valid,
    input logic [TID_W-1:0]     tid,
    input logic                 tid_err,
    input logic                 prog_en,
    input logic [FLAT_BITS-1:0] map_flat
);
    a_r4_valid_after_req: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |=> tid_valid);
    a_r4_idle_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_req |=> !tid_valid);
    a_r5_bad_sel: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_req && int'(lk_sel) >= NUM_TABLES) |=> (tid_err && tid == '0));
    a_r5_good_sel: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_req && int'(lk_sel) < NUM_TABLES) |=> !tid_err);
    a_r6_locked_map: assert property (@(posedge clk) disable iff (!rst_n)
        !prog_en |=> $stable(map_flat));
    a_r7_ctrl_high_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && int'(bus_addr) == CTRL_ADDR) |=> bus_rdata[WORD_W-1:1] == '0);
    a_r8_hole_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && int'(bus_addr) >= MAP_WORDS && int'(bus_addr) != CTRL_ADDR)
        |=> bus_rdata == '0);
endmodule

bind dscp_tid_classifier dtc_checker #(
    .NUM_TABLES(NUM_TABLES), .TID_W(TID_W), .WORD_W(WORD_W),
    .ADDR_W(ADDR_W), .SEL_W(SEL_W), .CTRL_ADDR(CTRL_ADDR),
    .MAP_WORDS(MAP_WORDS), .FLAT_BITS(FLAT_BITS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_rdata(bus_rdata), .lk_req(lk_req), .lk_sel(lk_sel),
    .tid_valid(tid_valid), .tid(tid), .tid_err(tid_err),
    .prog_en(prog_en), .map_flat(map_flat)
);

// File: tb/sim_dscp_tid_classifier.sv
`timescale 1ns/1ps
module sim_dscp_tid_classifier;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        lk_req = 1'b0;
    logic [5:0]  lk_dscp = '0;
    logic [1:0]  lk_sel = '0;
    logic        tid_valid, tid_err;
    logic [2:0]  tid;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [191:0] mdl [2];

    always #2 clk = ~clk;

    dscp_tid_classifier u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .lk_req(lk_req), .lk_dscp(lk_dscp), .lk_sel(lk_sel),
        .tid_valid(tid_valid), .tid(tid), .tid_err(tid_err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 5'(a); bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = 5'(a);
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic look(input int t, input int d, output logic v, output logic [2:0] r, output logic e);
        @(negedge clk);
        lk_req = 1'b1; lk_sel = 2'(t); lk_dscp = 6'(d);
        @(negedge clk);
        lk_req = 1'b0;
        v = tid_valid; r = tid; e = tid_err;
    endtask

    function automatic logic [2:0] exp_tid(input int t, input int d);
        return mdl[t][d*3 +: 3];
    endfunction

    task automatic sweep(input string req);
        logic v, e; logic [2:0] r;
        for (int t = 0; t < 2; t++)
            for (int d = 0; d < 64; d++) begin
                look(t, d, v, r, e);
                if (((d*3) % 32) > 29)
                    chk("R3 straddle", {27'd0, v, e, r}, {27'd0, 1'b1, 1'b0, exp_tid(t, d)});
                else
                    chk(req, {27'd0, v, e, r}, {27'd0, 1'b1, 1'b0, exp_tid(t, d)});
            end
    endtask

    task automatic readall(input string req);
        logic [31:0] q;
        for (int a = 0; a < 12; a++) begin
            rd(a, q);
            chk(req, q, mdl[a/6][(a%6)*32 +: 32]);
        end
    endtask

    // Software read-modify-write of one entry.
    task automatic rmw(input int t, input int d, input logic [2:0] val);
        logic [31:0] lo, hi; logic [63:0] pair;
        int b, w;
        b = d * 3; w = b / 32;
        rd(t*6 + w, lo);
        hi = '0;
        if (w < 5) rd(t*6 + w + 1, hi);
        pair = {hi, lo};
        pair[(b % 32) +: 3] = val;
        wr(t*6 + w, pair[31:0]);
        if (w < 5 && (b % 32) > 29) wr(t*6 + w + 1, pair[63:32]);
        mdl[t][b +: 3] = val;
    endtask

    initial begin
        #800000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] q; logic v, e; logic [2:0] r;
        mdl[0] = '0; mdl[1] = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 tid_valid", {31'd0, tid_valid}, 32'd0);
        rd(16, q); chk("R1 prog_en", q, 32'd0);
        readall("R1 map words");
        look(0, 10, v, r, e); chk("R1 lookup", {29'd0, r}, 32'd0);
        look(1, 63, v, r, e); chk("R1 lookup", {29'd0, r}, 32'd0);

        // R6 writes dropped while program-enable is clear
        wr(0, 32'hFFFF_FFFF); wr(11, 32'h1234_5678);
        readall("R6 locked write");

        // R7 control register
        wr(16, 32'hFFFF_FFFF);
        rd(16, q); chk("R7 ctrl", q, 32'd1);

        // R2/R10 fill both tables with a pattern and read back
        for (int a = 0; a < 12; a++) begin
            logic [31:0] p;
            p = (32'h9E37_79B9 * 32'(a + 1)) ^ (32'(a) << 9);
            wr(a, p);
            mdl[a/6][(a%6)*32 +: 32] = p;
        end
        readall("R10 readback");
        sweep("R2 lookup");

        // R5 selector range
        look(2, 5, v, r, e); chk("R5 sel2", {29'd0, v, e, r[0]}, {29'd0, 1'b1, 1'b1, 1'b0});
        chk("R5 sel2 tid", {29'd0, r}, 32'd0);
        look(3, 21, v, r, e); chk("R5 sel3", {28'd0, v, e, r}, {28'd0, 1'b1, 1'b1, 3'd0});

        // R4 valid only for one cycle after a request
        look(0, 1, v, r, e);
        @(negedge clk);
        chk("R4 valid drops", {31'd0, tid_valid}, 32'd0);
        @(negedge clk);
        lk_req = 1'b1; lk_sel = 2'd1; lk_dscp = 6'd2;
        @(negedge clk);
        chk("R4 back-to-back a", {28'd0, tid_valid, tid}, {28'd0, 1'b1, exp_tid(1, 2)});
        lk_dscp = 6'd42;
        @(negedge clk);
        lk_req = 1'b0;
        chk("R4 back-to-back b", {28'd0, tid_valid, tid}, {28'd0, 1'b1, exp_tid(1, 42)});

        // R8 unmapped addresses
        for (int a = 12; a < 32; a++)
            if (a != 16) wr(a, 32'hA5A5_A5A5 ^ 32'(a));
        for (int a = 12; a < 32; a++)
            if (a != 16) begin
                rd(a, q); chk("R8 hole read", q, 32'd0);
            end
        rd(16, q); chk("R8 ctrl kept", q, 32'd1);
        readall("R8 map kept");

        // R11 single-entry read-modify-write, including straddling entries
        rmw(1, 21, 3'd5);
        rmw(0, 10, ~exp_tid(0, 10));
        rmw(0, 0, 3'd7);
        rmw(1, 63, 3'd2);
        sweep("R11 neighbours");

        // R9 same-cycle write and lookup
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 5'd6; bus_wdata = ~mdl[1][31:0];
        lk_req = 1'b1; lk_sel = 2'd1; lk_dscp = 6'd1;
        @(negedge clk);
        bus_wr = 1'b0;
        chk("R9 old value", {28'd0, tid_valid, tid}, {28'd0, 1'b1, exp_tid(1, 1)});
        mdl[1][31:0] = ~mdl[1][31:0];
        @(negedge clk);
        lk_req = 1'b0;
        chk("R9 new value", {28'd0, tid_valid, tid}, {28'd0, 1'b1, exp_tid(1, 1)});

        // R6 lock again: writes dropped, reads still served
        wr(16, 32'd0);
        rd(16, q); chk("R7 ctrl clear", q, 32'd0);
        wr(3, 32'h0);
        wr(9, 32'hDEAD_BEEF);
        readall("R6 read while locked");
        look(0, 53, v, r, e); chk("R3 locked lookup", {29'd0, r}, {29'd0, exp_tid(0, 53)});

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule